// File: doc/BRIEF.md
# Dual-Channel Byte Lane Packer

The packer moves bytes from a bank of thirteen byte-wide source queues into a 32-bit transfer queue. Two DMA channels share it. Each channel has one configuration word that holds a source code and a byte count. When a channel has work, the packer pops bytes one at a time from the chosen source and places four of them in each longword. It then pushes the longword to the transfer queue. The count field decrements as bytes are taken, so software reading the word sees how many bytes are still owed.

When the count runs out partway through a longword, the unused lanes are pushed as zeros. The number of zero lanes is kept in a per-channel read-only pad register. A global word sets which end of the longword the first byte of each group goes to. The same word drives a level output that holds the transfer queue in partial reset. Channel A wins whenever both channels are waiting. A channel that has started finishes before the other channel is considered.

Top module: `byte_lane_packer`

## Requirements
- R1: After reset, the register port reads as follows: word 0 through word 3 read 0, word 4 (global) reads 0x2, and words 5 to 7 read 0. While reset is applied and after it, no source is popped, nothing is pushed and `xfer_flush` is low.
- R2: A channel word (word 0 = channel A, word 1 = channel B) holds the source code in bits 20:17. Codes 0 to 12 pick source queue 0 to 12, and only that queue is popped. Codes 13, 14 and 15 pick no source: nothing is popped, nothing is pushed, and the word keeps its value.
- R3: Bits 16:0 of a channel word hold the remaining byte count. The count drops by one for every byte popped for that channel, and a read returns the live value.
- R4: Four consecutive bytes form one pushed longword. With global bit 0 at 0, the first byte of the group goes to bits 31:24 and later bytes go to lower lanes. With global bit 0 at 1, the first byte goes to bits 7:0 and later bytes go to higher lanes.
- R5: When the count reaches zero with a longword partly filled, that longword is pushed with its empty lanes at 0x00. The number of empty lanes, from 0 to 3, is then readable in bits 16:0 of the channel's pad word (word 2 = channel A, word 3 = channel B).
- R6: If both channels have work when the packer is idle, channel A is served first. Channel B's word does not change until A has pushed its final longword.
- R7: While `xfer_full` is high, `xfer_push` stays low, no source is popped, and the waiting longword is kept. Once `xfer_full` falls, that longword is pushed intact.
- R8: A write to the word of the channel that is currently transferring is ignored. A write to the other channel's word takes effect.
- R9: `xfer_flush` is high exactly while global bit 1 is 0.
- R10: While the selected source is not ready, the packer waits. Nothing is popped and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index, for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| src_ready | input | 13 | Source queue holds at least one byte |
| src_data | input | 104 | Head byte of each source; source i is in bits 8i+7:8i |
| src_pop | output | 13 | Pops the head byte of a source (at most one bit set) |
| xfer_full | input | 1 | Transfer queue cannot accept a longword |
| xfer_push | output | 1 | Writes `xfer_data` into the transfer queue |
| xfer_data | output | 32 | Packed longword |
| xfer_flush | output | 1 | Holds the transfer queue in partial reset |

## Verification
A write shows on `reg_rdata` one cycle after the write strobe. The first pop comes two cycles after a channel word gains work, because the packer needs one idle cycle to pick a channel. A push is offered in the cycle after the pop that fills a longword or ends the count. The pad count and the live count are readable in that same cycle. Inputs change just after each rising edge. The bench's model advances on the rising edge, and every output is compared with it at the following falling edge. Each result is therefore judged in exactly the cycle its registers place it.

// File: rtl/bpk_pkg.sv
package bpk_pkg;

    localparam int BPK_NUM_SRC = 13;
    localparam int BPK_SEL_W   = 4;
    localparam int BPK_CNT_W   = 17;
    localparam int BPK_NUM_CH  = 2;
    localparam int BPK_BYTE_W  = 8;
    localparam int BPK_LANES   = 4;
    localparam int BPK_ADDR_W  = 3;

    localparam int BPK_WORD_W  = BPK_BYTE_W * BPK_LANES;
    localparam int BPK_IDX_W   = $clog2(BPK_LANES);
    localparam int BPK_POS_W   = $clog2(BPK_WORD_W);
    localparam int BPK_CH_W    = (BPK_NUM_CH > 1) ? $clog2(BPK_NUM_CH) : 1;
    localparam int BPK_GLOB_IX = 2 * BPK_NUM_CH;

    // channel word: source code above the live count
    typedef struct packed {
        logic [BPK_SEL_W-1:0] sel;
        logic [BPK_CNT_W-1:0] rem;
    } chan_cfg_t;

    localparam int BPK_CFG_W = $bits(chan_cfg_t);

    typedef struct packed {
        logic flush_n;
        logic lsb_first;
    } glob_cfg_t;

    typedef enum logic [1:0] {
        PK_IDLE = 2'd0,
        PK_FILL = 2'd1,
        PK_PUSH = 2'd2
    } pk_state_e;

    function automatic logic chan_has_work(input chan_cfg_t c);
        return (c.rem != '0) && (c.sel < BPK_SEL_W'(BPK_NUM_SRC));
    endfunction

    // bit offset of lane slot idx under the selected ordering
    function automatic logic [BPK_POS_W-1:0] lane_pos(input logic [BPK_IDX_W-1:0] idx,
                                                      input logic lsb_first);
        logic [BPK_IDX_W-1:0] slot;
        slot = lsb_first ? idx : (BPK_IDX_W'(BPK_LANES - 1) - idx);
        return BPK_POS_W'(slot) << $clog2(BPK_BYTE_W);
    endfunction

endpackage

// File: rtl/bpk_regs.sv
module bpk_regs
    import bpk_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                we,
    input  logic [BPK_ADDR_W-1:0]               addr,
    input  logic [BPK_WORD_W-1:0]               wdata,
    output logic [BPK_WORD_W-1:0]               rdata,
    input  logic                                busy,
    input  logic [BPK_CH_W-1:0]                 cur_ch,
    input  logic                                take,
    input  logic                                pad_we,
    input  logic [BPK_CNT_W-1:0]                pad_val,
    output chan_cfg_t [BPK_NUM_CH-1:0]          cfg,
    output logic                                cfg_wr,
    output logic                                lsb_first,
    output logic                                flush
);

    chan_cfg_t [BPK_NUM_CH-1:0]          cfg_q;
    logic [BPK_NUM_CH-1:0][BPK_CNT_W-1:0] pad_q;
    glob_cfg_t                           glob_q;
    logic [BPK_NUM_CH-1:0]               wr_hit;
    logic [BPK_NUM_CH-1:0]               dec_hit;
    logic [BPK_NUM_CH-1:0]               owner;

    always_comb begin
        cfg_wr = 1'b0;
        for (int c = 0; c < BPK_NUM_CH; c++) begin
            owner[c]   = busy && (cur_ch == BPK_CH_W'(c));
            wr_hit[c]  = we && (addr == BPK_ADDR_W'(c)) && !owner[c];
            dec_hit[c] = take && owner[c];
            if (we && (addr == BPK_ADDR_W'(c)))
                cfg_wr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            pad_q  <= '0;
            glob_q <= '{flush_n: 1'b1, lsb_first: 1'b0};
        end else begin
            for (int c = 0; c < BPK_NUM_CH; c++) begin
                if (wr_hit[c])
                    cfg_q[c] <= chan_cfg_t'(wdata[BPK_CFG_W-1:0]);
                else if (dec_hit[c])
                    cfg_q[c].rem <= cfg_q[c].rem - 1'b1;
                if (pad_we && owner[c])
                    pad_q[c] <= pad_val;
            end
            if (we && (addr == BPK_ADDR_W'(BPK_GLOB_IX)))
                glob_q <= glob_cfg_t'(wdata[$bits(glob_cfg_t)-1:0]);
        end
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < BPK_NUM_CH; c++) begin
            if (addr == BPK_ADDR_W'(c))
                rdata = BPK_WORD_W'(cfg_q[c]);
            if (addr == BPK_ADDR_W'(BPK_NUM_CH + c))
                rdata = BPK_WORD_W'(pad_q[c]);
        end
        if (addr == BPK_ADDR_W'(BPK_GLOB_IX))
            rdata = BPK_WORD_W'(glob_q);
    end

    assign cfg       = cfg_q;
    assign lsb_first = glob_q.lsb_first;
    assign flush     = !glob_q.flush_n;

    for (genvar g = 0; g < BPK_NUM_CH; g++) begin : g_chk
        AST_REM_STEP: assert property (@(posedge clk) disable iff (rst)
            dec_hit[g] |=> (cfg_q[g].rem == $past(cfg_q[g].rem) - 1'b1)); // R3
        AST_ACTIVE_LOCKED: assert property (@(posedge clk) disable iff (rst)
            (owner[g] && !dec_hit[g]) |=> $stable(cfg_q[g])); // R8
    end

endmodule

// File: rtl/bpk_src_mux.sv
module bpk_src_mux
    import bpk_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic [BPK_NUM_SRC-1:0]             src_ready,
    input  logic [BPK_NUM_SRC*BPK_BYTE_W-1:0]  src_data,
    input  logic [BPK_SEL_W-1:0]               sel,
    input  logic                               take,
    output logic                               sel_ready,
    output logic [BPK_BYTE_W-1:0]              sel_byte,
    output logic [BPK_NUM_SRC-1:0]             src_pop
);

    logic [BPK_NUM_SRC-1:0] hit;

    for (genvar i = 0; i < BPK_NUM_SRC; i++) begin : g_src
        assign hit[i]     = (sel == BPK_SEL_W'(i));
        assign src_pop[i] = take && hit[i];
    end

    always_comb begin
        sel_ready = 1'b0;
        sel_byte  = '0;
        for (int i = 0; i < BPK_NUM_SRC; i++) begin
            if (hit[i]) begin
                sel_ready = src_ready[i];
                sel_byte  = src_data[i*BPK_BYTE_W +: BPK_BYTE_W];
            end
        end
    end

    AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_pop)); // R2
    AST_POP_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        ((src_pop & ~src_ready) == '0)); // R10

endmodule

// File: rtl/bpk_packer_core.sv
module bpk_packer_core
    import bpk_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  chan_cfg_t [BPK_NUM_CH-1:0]    cfg,
    input  logic                          cfg_wr,
    input  logic                          lsb_first,
    input  logic                          sel_ready,
    input  logic [BPK_BYTE_W-1:0]         sel_byte,
    input  logic                          out_full,
    output logic                          take,
    output logic                          busy,
    output logic [BPK_CH_W-1:0]           cur_ch,
    output logic [BPK_SEL_W-1:0]          cur_sel,
    output logic                          push,
    output logic [BPK_WORD_W-1:0]         word,
    output logic                          pad_we,
    output logic [BPK_CNT_W-1:0]          pad_val
);

    pk_state_e              state_q;
    logic [BPK_CH_W-1:0]    ch_q;
    logic [BPK_IDX_W-1:0]   idx_q;
    logic [BPK_WORD_W-1:0]  acc_q;
    chan_cfg_t              cur;
    logic                   pick_ok;
    logic [BPK_CH_W-1:0]    pick_ch;
    logic                   last_byte;
    logic                   word_done;

    // lowest channel index with work wins
    always_comb begin
        pick_ok = 1'b0;
        pick_ch = '0;
        for (int c = BPK_NUM_CH - 1; c >= 0; c--) begin
            if (chan_has_work(cfg[c])) begin
                pick_ok = 1'b1;
                pick_ch = BPK_CH_W'(c);
            end
        end
    end

    assign cur       = cfg[ch_q];
    assign cur_ch    = ch_q;
    assign cur_sel   = cur.sel;
    assign busy      = (state_q != PK_IDLE);
    assign take      = (state_q == PK_FILL) && sel_ready;
    assign last_byte = (cur.rem == BPK_CNT_W'(1));
    assign word_done = (idx_q == BPK_IDX_W'(BPK_LANES - 1));
    assign push      = (state_q == PK_PUSH) && !out_full;
    assign word      = acc_q;
    assign pad_we    = take && last_byte;
    assign pad_val   = BPK_CNT_W'(BPK_IDX_W'(BPK_LANES - 1) - idx_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PK_IDLE;
            ch_q    <= '0;
            idx_q   <= '0;
            acc_q   <= '0;
        end else begin
            unique case (state_q)
                PK_IDLE: begin
                    if (pick_ok && !cfg_wr) begin
                        ch_q    <= pick_ch;
                        state_q <= PK_FILL;
                    end
                end
                PK_FILL: begin
                    if (take) begin
                        acc_q[lane_pos(idx_q, lsb_first) +: BPK_BYTE_W] <= sel_byte;
                        idx_q <= idx_q + 1'b1;
                        if (last_byte || word_done)
                            state_q <= PK_PUSH;
                    end
                end
                PK_PUSH: begin
                    if (!out_full) begin
                        acc_q   <= '0;
                        idx_q   <= '0;
                        state_q <= (cur.rem == '0) ? PK_IDLE : PK_FILL;
                    end
                end
                default: state_q <= PK_IDLE;
            endcase
        end
    end

    AST_HOLD_WHILE_FULL: assert property (@(posedge clk) disable iff (rst)
        (state_q == PK_PUSH && out_full) |=> (state_q == PK_PUSH && $stable(acc_q))); // R7
    AST_A_FIRST: assert property (@(posedge clk) disable iff (rst)
        (state_q == PK_IDLE && !cfg_wr && chan_has_work(cfg[0]))
            |=> (state_q == PK_FILL && ch_q == '0)); // R6
    AST_FINAL_GOES_IDLE: assert property (@(posedge clk) disable iff (rst)
        (push && cur.rem == '0) |=> (state_q == PK_IDLE)); // R5

endmodule

// File: rtl/byte_lane_packer.sv
module byte_lane_packer
    import bpk_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               reg_we,
    input  logic [BPK_ADDR_W-1:0]              reg_addr,
    input  logic [BPK_WORD_W-1:0]              reg_wdata,
    output logic [BPK_WORD_W-1:0]              reg_rdata,
    input  logic [BPK_NUM_SRC-1:0]             src_ready,
    input  logic [BPK_NUM_SRC*BPK_BYTE_W-1:0]  src_data,
    output logic [BPK_NUM_SRC-1:0]             src_pop,
    input  logic                               xfer_full,
    output logic                               xfer_push,
    output logic [BPK_WORD_W-1:0]              xfer_data,
    output logic                               xfer_flush
);

    chan_cfg_t [BPK_NUM_CH-1:0] cfg;
    logic                       cfg_wr;
    logic                       lsb_first;
    logic                       take;
    logic                       busy;
    logic [BPK_CH_W-1:0]        cur_ch;
    logic [BPK_SEL_W-1:0]       cur_sel;
    logic                       sel_ready;
    logic [BPK_BYTE_W-1:0]      sel_byte;
    logic                       pad_we;
    logic [BPK_CNT_W-1:0]       pad_val;

    bpk_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .busy      (busy),
        .cur_ch    (cur_ch),
        .take      (take),
        .pad_we    (pad_we),
        .pad_val   (pad_val),
        .cfg       (cfg),
        .cfg_wr    (cfg_wr),
        .lsb_first (lsb_first),
        .flush     (xfer_flush)
    );

    bpk_src_mux u_mux (
        .clk       (clk),
        .rst       (rst),
        .src_ready (src_ready),
        .src_data  (src_data),
        .sel       (cur_sel),
        .take      (take),
        .sel_ready (sel_ready),
        .sel_byte  (sel_byte),
        .src_pop   (src_pop)
    );

    bpk_packer_core u_core (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .cfg_wr    (cfg_wr),
        .lsb_first (lsb_first),
        .sel_ready (sel_ready),
        .sel_byte  (sel_byte),
        .out_full  (xfer_full),
        .take      (take),
        .busy      (busy),
        .cur_ch    (cur_ch),
        .cur_sel   (cur_sel),
        .push      (xfer_push),
        .word      (xfer_data),
        .pad_we    (pad_we),
        .pad_val   (pad_val)
    );

    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        xfer_full |-> !xfer_push); // R7
    AST_NO_POP_IN_RESET: assert property (@(posedge clk)
        rst |-> (src_pop == '0 && !xfer_push)); // R1

endmodule

// File: tb/tb_byte_lane_packer.sv
module tb_byte_lane_packer;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 13;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [12:0]  src_ready = '0;
    logic [103:0] src_data = '0;
    logic [12:0]  src_pop;
    logic         xfer_full = 1'b0;
    logic         xfer_push;
    logic [31:0]  xfer_data;
    logic         xfer_flush;

    byte_lane_packer dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_ready(src_ready),
        .src_data(src_data), .src_pop(src_pop), .xfer_full(xfer_full),
        .xfer_push(xfer_push), .xfer_data(xfer_data), .xfer_flush(xfer_flush)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // stimulus storage
    logic [7:0] mem [NSRC][64];
    int head [NSRC];
    int tail [NSRC];
    bit [12:0] hold = '0;

    // reference model state
    int m_st, m_ch, m_idx, m_g;
    int m_sel [2];
    int m_rem [2];
    int m_fill [2];
    logic [31:0] m_acc;

    logic [31:0] plog [256];
    int np = 0;
    logic [31:0] last_rdata;
    bit started = 0;
    int n_cmp = 0, n_bad = 0;

    function automatic logic [7:0] bval(int s, int k);
        return 8'((s * 37 + k * 5 + 3) & 255);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic bit work(int c);
        return m_rem[c] != 0 && m_sel[c] < 13;
    endfunction

    function automatic logic [31:0] exp_rd(int a);
        case (a)
            0, 1: return 32'((m_sel[a] << 17) | m_rem[a]);
            2, 3: return 32'(m_fill[a-2]);
            4:    return 32'(m_g);
            default: return 32'h0;
        endcase
    endfunction

    task automatic drive_src();
        for (int i = 0; i < NSRC; i++) begin
            src_ready[i] = (head[i] < tail[i]) && !hold[i];
            src_data[i*8 +: 8] = (head[i] < tail[i]) ? mem[i][head[i]] : 8'h00;
        end
    endtask

    task automatic load_src(int s, int n);
        for (int k = 0; k < n; k++) begin
            mem[s][tail[s]] = bval(s, tail[s]);
            tail[s]++;
        end
    endtask

    task automatic compare_all();
        logic [12:0] epop;
        bit epush;
        epush = (m_st == 2) && !xfer_full;
        epop = '0;
        if (m_st == 1 && src_ready[m_sel[m_ch]]) epop[m_sel[m_ch]] = 1'b1;
        check("R7 push", 32'(xfer_push), 32'(epush));
        if (epush) check("R4 data", xfer_data, m_acc);
        check("R2 pop", 32'(src_pop), 32'(epop));
        check("R3 rdata", reg_rdata, exp_rd(int'(reg_addr)));
        check("R9 flush", 32'(xfer_flush), 32'(((m_g >> 1) & 1) == 0));
    endtask

    task automatic model_update();
        int s, pos, wch;
        bit take, dopush, wrc, was_busy;
        if (rst) begin
            m_st = 0; m_ch = 0; m_idx = 0; m_g = 2; m_acc = '0;
            for (int c = 0; c < 2; c++) begin m_sel[c] = 0; m_rem[c] = 0; m_fill[c] = 0; end
            return;
        end
        was_busy = (m_st != 0);
        wch = m_ch;
        s = m_sel[m_ch];
        take = (m_st == 1) && src_ready[s];
        dopush = (m_st == 2) && !xfer_full;
        wrc = reg_we && reg_addr < 2;
        if (m_st == 0) begin
            if (!wrc) begin
                if (work(0)) begin m_ch = 0; m_st = 1; end
                else if (work(1)) begin m_ch = 1; m_st = 1; end
            end
        end else if (take) begin
            pos = (m_g & 1) ? m_idx * 8 : (3 - m_idx) * 8;
            m_acc[pos +: 8] = mem[s][head[s]];
            head[s]++;
            m_rem[m_ch]--;
            if (m_rem[m_ch] == 0) begin m_fill[m_ch] = 3 - m_idx; m_st = 2; end
            else if (m_idx == 3) m_st = 2;
            m_idx++;
        end else if (dopush) begin
            m_acc = '0; m_idx = 0;
            m_st = (m_rem[m_ch] == 0) ? 0 : 1;
        end
        if (reg_we) begin
            if (reg_addr < 2 && !(was_busy && wch == int'(reg_addr))) begin
                m_sel[reg_addr] = (reg_wdata >> 17) & 15;
                m_rem[reg_addr] = reg_wdata & 32'h1FFFF;
            end
            if (reg_addr == 4) m_g = reg_wdata & 3;
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (started) compare_all();
        if (xfer_push) begin plog[np] = xfer_data; np++; end
        last_rdata = reg_rdata;
        @(posedge clk);
        model_update();
        started = 1;
        #1;
        drive_src();
    endtask

    task automatic wr(int a, logic [31:0] d);
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        step();
        reg_we = 1'b0; reg_addr = 3'd0;
    endtask

    task automatic rd(int a, logic [31:0] exp, string tag);
        reg_addr = 3'(a);
        step();
        check(tag, last_rdata, exp);
        reg_addr = 3'd0;
    endtask

    task automatic run_idle();
        for (int i = 0; i < 500; i++) begin
            if (m_st == 0 && !work(0) && !work(1)) break;
            step();
        end
        step();
    endtask

    function automatic logic [31:0] msbw(int s, int k, int n);
        logic [31:0] w = '0;
        for (int j = 0; j < n; j++) w[(3-j)*8 +: 8] = bval(s, k + j);
        return w;
    endfunction

    function automatic logic [31:0] lsbw(int s, int k, int n);
        logic [31:0] w = '0;
        for (int j = 0; j < n; j++) w[j*8 +: 8] = bval(s, k + j);
        return w;
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL R1 watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        int base, p0;
        for (int i = 0; i < NSRC; i++) begin head[i] = 0; tail[i] = 0; end
        drive_src();
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1: reset values of every word
        for (int a = 0; a < 8; a++) rd(a, (a == 4) ? 32'h2 : 32'h0, "R1 reset read");
        check("R1 no push", 32'(xfer_push), 32'h0);
        check("R1 flush low", 32'(xfer_flush), 32'h0);

        // R4 most-significant-first, exact multiple: no pads (R5)
        p0 = np; base = tail[0];
        load_src(0, 8);
        wr(0, (0 << 17) | 8);
        run_idle();
        check("R4 msb word0", plog[p0], msbw(0, base, 4));
        check("R4 msb word1", plog[p0+1], msbw(0, base + 4, 4));
        rd(2, 32'h0, "R5 pad zero");

        // R4 least-significant-first with partial tail (R5)
        wr(4, 32'h3);
        p0 = np; base = tail[12];
        load_src(12, 6);
        wr(0, (12 << 17) | 6);
        run_idle();
        check("R4 lsb word0", plog[p0], lsbw(12, base, 4));
        check("R5 pad word", plog[p0+1], lsbw(12, base + 4, 2));
        rd(2, 32'h2, "R5 pad count A");
        rd(0, 32'(12 << 17), "R3 count zero");

        // R2: reserved code does nothing
        wr(4, 32'h2);
        p0 = np;
        load_src(13 - 1, 0);
        wr(1, (13 << 17) | 5);
        repeat (20) step();
        check("R2 no push", 32'(np), 32'(p0));
        rd(1, 32'((13 << 17) | 5), "R2 word kept");
        wr(1, 32'h0);

        // R6: A served first, B untouched meanwhile
        p0 = np;
        load_src(1, 4); load_src(2, 4);
        base = tail[1] - 4;
        wr(0, (1 << 17) | 4);
        wr(1, (2 << 17) | 4);
        step(); step();
        rd(1, 32'((2 << 17) | 4), "R6 B waits");
        run_idle();
        check("R6 A word first", plog[p0], msbw(1, base, 4));
        check("R6 B word second", plog[p0+1], msbw(2, tail[2] - 4, 4));

        // R7 stall on full, R8 write lock
        p0 = np; base = tail[3];
        load_src(3, 8);
        load_src(4, 2);
        wr(0, (3 << 17) | 8);
        for (int i = 0; i < 50 && m_st != 2; i++) step();
        xfer_full = 1'b1;
        repeat (10) step();
        check("R7 held while full", 32'(np), 32'(p0));
        wr(0, (5 << 17) | 100);
        rd(0, 32'((3 << 17) | 4), "R8 active write ignored");
        wr(1, (4 << 17) | 2);
        rd(1, 32'((4 << 17) | 2), "R8 other channel write");
        xfer_full = 1'b0;
        run_idle();
        check("R7 word0 intact", plog[p0], msbw(3, base, 4));
        check("R7 word1 intact", plog[p0+1], msbw(3, base + 4, 4));
        check("R5 B pad word", plog[p0+2], msbw(4, tail[4] - 2, 2));
        rd(3, 32'h2, "R5 pad count B");

        // R10: wait on an empty or held source
        p0 = np; base = tail[6];
        load_src(6, 2);
        hold[6] = 1'b1; drive_src();
        wr(0, (6 << 17) | 3);
        repeat (10) step();
        rd(0, 32'((6 << 17) | 3), "R10 count held");
        hold[6] = 1'b0; drive_src();
        repeat (10) step();
        rd(0, 32'((6 << 17) | 1), "R10 waits when empty");
        load_src(6, 1); drive_src();
        run_idle();
        check("R10 word", plog[p0], msbw(6, base, 3));
        rd(2, 32'h1, "R5 pad one");

        // R9: flush follows global bit 1
        wr(4, 32'h0);
        step();
        check("R9 flush high", 32'(xfer_flush), 32'h1);
        wr(4, 32'h2);
        step();
        check("R9 flush low", 32'(xfer_flush), 32'h0);

        finish_run();
    end

endmodule